// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block watches the access strobes of an SRAM bus and looks for one of two fixed six-address read sequences. When the reads arrive in exact order, it starts a nonvolatile transfer. A full store sequence raises a one-cycle store start pulse. A full recall sequence raises a one-cycle recall start pulse. Both sequences share their first five addresses and differ only in the sixth.

Each access counts once, on the rising edge of a strobe that has already been qualified by chip enable. A 13-bit address and a write flag go with each access. A write at any point kills the attempt in progress, and so does a read of any address other than the one expected next. An aborting read of address 0x0000 is treated as a fresh first step.

Once a transfer starts, the block drops its I/O enable and ignores all accesses. It stays in this state until the array reports completion on the done input. A store's erase and program phases are both covered by that single done indication.

Top module: `nvCmdDetect`

## Requirements
- R1: After reset, busy is 0, ioEnable is 1, no start pulse is high, and the match state is at the first step.
- R2: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order, raise storeStart in the clock cycle after the strobe edge of the sixth read.
- R3: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0E, in that order, raise recallStart in the clock cycle after the strobe edge of the sixth read.
- R4: A write access at any step aborts the sequence, even when its address equals the expected one. A later read then has to begin again with 0x0000.
- R5: A read of an address other than the expected next one aborts the sequence. If that read is 0x0000, matching resumes at step two; otherwise it resumes at step one.
- R6: A strobe held high for several clock cycles counts as a single access. Only a low-to-high transition of accStrobe advances the detector.
- R7: While busy is 1, ioEnable is 0 and all accesses are ignored. A complete sequence issued while busy produces no pulse. Matching restarts from step one once busy clears.
- R8: busy rises with a start pulse and stays 1 until xferDone is sampled high. In the next cycle, busy is 0 and ioEnable is 1. xferDone has no effect while idle.
- R9: Each start pulse lasts exactly one cycle. storeStart and recallStart are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accStrobe | input | 1 | Chip-enable-qualified access strobe; its rising edge marks one access |
| accAddr | input | ADDR_W (13) | Access address |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| xferDone | input | 1 | Array reports that the running transfer has finished |
| storeStart | output | 1 | One-cycle pulse starting a store transfer |
| recallStart | output | 1 | One-cycle pulse starting a recall transfer |
| busy | output | 1 | A transfer is in progress |
| ioEnable | output | 1 | SRAM I/O allowed; low while busy |

## Verification
The hardest case to reach from the ports is a restart inside a partial match. A read of 0x0000 arrives where a later address was expected, and the sequence that follows must still succeed from step two. The stimulus interleaves a stray 0x0000 after two good reads, then sends the remaining five addresses. The scoreboard expects exactly one store pulse. A second hard case is a strobe held high across a step boundary. A detector that counts levels instead of edges would see 0x1555 twice and abort, so the scoreboard would be left with an unfulfilled expectation.

// File: rtl/nvCmdPkg.sv
package nvCmdPkg;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);
  localparam logic [15:0] STORE_TAIL  = 16'h0F0F;
  localparam logic [15:0] RECALL_TAIL = 16'h0F0E;

  // shared prefix of both sequences, step index 0 .. SEQ_LEN-2
  function automatic logic [15:0] prefixAddr(input int idx);
    case (idx)
      0:       prefixAddr = 16'h0000;
      1:       prefixAddr = 16'h1555;
      2:       prefixAddr = 16'h0AAA;
      3:       prefixAddr = 16'h1FFF;
      4:       prefixAddr = 16'h10F0;
      default: prefixAddr = 16'h0000;
    endcase
  endfunction

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic              armed;
  } ctlToPath_t;

  typedef struct packed {
    logic acc;
    logic isWrite;
    logic hitNext;
    logic hitHead;
    logic hitStoreTail;
    logic hitRecallTail;
  } pathToCtl_t;
endpackage

// File: rtl/nvCmdPath.sv
module nvCmdPath
  import nvCmdPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStrobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  ctlToPath_t        ctl,
  output pathToCtl_t        stat
);
  logic prevStrobe;
  logic [SEQ_LEN-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevStrobe <= 1'b0;
    else       prevStrobe <= accStrobe;
  end

  for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_prefix
    assign hitVec[i] = (accAddr == ADDR_W'(prefixAddr(i)));
  end
  assign hitVec[SEQ_LEN-1] = 1'b0;

  always_comb begin
    stat.acc           = accStrobe & ~prevStrobe & ctl.armed;
    stat.isWrite       = accWrite;
    stat.hitNext       = hitVec[ctl.step];
    stat.hitHead       = hitVec[0];
    stat.hitStoreTail  = (accAddr == ADDR_W'(STORE_TAIL));
    stat.hitRecallTail = (accAddr == ADDR_W'(RECALL_TAIL));
  end
endmodule

// File: rtl/nvCmdCtrl.sv
module nvCmdCtrl
  import nvCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pathToCtl_t stat,
  input  logic       xferDone,
  output ctlToPath_t ctl,
  output logic       storeStart,
  output logic       recallStart,
  output logic       busy,
  output logic       ioEnable
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step, nStep;
  logic nBusy, nStore, nRecall;

  always_comb begin
    nStep   = step;
    nBusy   = busy;
    nStore  = 1'b0;
    nRecall = 1'b0;
    if (busy) begin
      if (xferDone) begin
        nBusy = 1'b0;
        nStep = '0;
      end
    end else if (stat.acc) begin
      if (stat.isWrite) begin
        nStep = '0;
      end else if (step == LAST) begin
        if (stat.hitStoreTail) begin
          nStore = 1'b1;
          nBusy  = 1'b1;
          nStep  = '0;
        end else if (stat.hitRecallTail) begin
          nRecall = 1'b1;
          nBusy   = 1'b1;
          nStep   = '0;
        end else begin
          nStep = stat.hitHead ? STEP_W'(1) : '0;
        end
      end else if (stat.hitNext) begin
        nStep = step + STEP_W'(1);
      end else begin
        nStep = stat.hitHead ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step        <= '0;
      busy        <= 1'b0;
      ioEnable    <= 1'b1;
      storeStart  <= 1'b0;
      recallStart <= 1'b0;
    end else begin
      step        <= nStep;
      busy        <= nBusy;
      ioEnable    <= ~nBusy;
      storeStart  <= nStore;
      recallStart <= nRecall;
    end
  end

  assign ctl.step  = step;
  assign ctl.armed = ~busy;
endmodule

// File: rtl/nvCmdDetect.sv
module nvCmdDetect
  import nvCmdPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accStrobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              xferDone,
  output logic              storeStart,
  output logic              recallStart,
  output logic              busy,
  output logic              ioEnable
);
  ctlToPath_t ctl;
  pathToCtl_t stat;

  nvCmdPath #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accAddr(accAddr),
    .accWrite(accWrite), .ctl(ctl), .stat(stat)
  );

  nvCmdCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .xferDone(xferDone), .ctl(ctl),
    .storeStart(storeStart), .recallStart(recallStart), .busy(busy),
    .ioEnable(ioEnable)
  );
endmodule

// File: rtl/nvCmdChk.sv
module nvCmdChk (
  input logic clk,
  input logic rstN,
  input logic storeStart,
  input logic recallStart,
  input logic busy,
  input logic ioEnable,
  input logic xferDone
);
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeStart, recallStart})); // R9
  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    storeStart |=> !storeStart); // R9
  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |=> !recallStart); // R9
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (storeStart || recallStart) |-> (busy && !$past(busy))); // R8
  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ioEnable); // R7
  AST_IO_OPEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ioEnable); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone) |=> busy); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferDone) |=> !busy); // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !(storeStart || recallStart)); // R7
endmodule

bind nvCmdDetect nvCmdChk u_chk (
  .clk(clk), .rstN(rstN), .storeStart(storeStart), .recallStart(recallStart),
  .busy(busy), .ioEnable(ioEnable), .xferDone(xferDone)
);

// File: tb/nvCmdDetect_bench.sv
module nvCmdDetect_bench;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accStrobe = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic accWrite = 1'b0;
  logic xferDone = 1'b0;
  logic storeStart, recallStart, busy, ioEnable;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected pulse kinds: 1 = store, 2 = recall
  int expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  nvCmdDetect #(.ADDR_W(ADDR_W)) u_nvCmdDetect (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .accAddr(accAddr),
    .accWrite(accWrite), .xferDone(xferDone), .storeStart(storeStart),
    .recallStart(recallStart), .busy(busy), .ioEnable(ioEnable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected pulses as they appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (storeStart && recallStart)
        check(1'b0, "R9", "both pulses high", 3, 1);
      else if (storeStart || recallStart) begin
        int kind;
        kind = storeStart ? 1 : 2;
        if (expQ.size() == 0)
          check(1'b0, "R7", "unexpected start pulse kind", kind, 0);
        else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(kind == e, t, "start pulse kind", kind, e);
        end
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input int hold);
    @(negedge clk);
    accAddr = a;
    accWrite = wr;
    accStrobe = 1'b1;
    repeat (hold) @(negedge clk);
    accStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    access(a, 1'b0, 1);
  endtask

  task automatic prefix5();
    rd(13'h0000); rd(13'h1555); rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0);
  endtask

  task automatic expectPulse(input int kind, input string tag);
    expQ.push_back(kind);
    tagQ.push_back(tag);
  endtask

  task automatic finishXfer(input string tag);
    check(busy == 1'b1, tag, "busy during transfer", busy, 1);
    check(ioEnable == 1'b0, "R7", "ioEnable during transfer", ioEnable, 0);
    @(negedge clk);
    check(busy == 1'b1, "R8", "busy holds without done", busy, 1);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    check(ioEnable == 1'b1, "R8", "ioEnable after done", ioEnable, 1);
  endtask

  task automatic checkIdle(input string tag);
    check(expQ.size() == 0, tag, "pending expected pulses", expQ.size(), 0);
    check(busy == 1'b0, tag, "busy idle", busy, 0);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(ioEnable == 1'b1, "R1", "ioEnable in reset", ioEnable, 1);
    check(storeStart == 1'b0 && recallStart == 1'b0, "R1", "pulses in reset",
          storeStart + recallStart, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R8 done while idle has no effect
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    check(busy == 1'b0 && ioEnable == 1'b1, "R8", "done while idle", busy, 0);

    // R2 store sequence
    expectPulse(1, "R2");
    prefix5(); rd(13'h0F0F);
    finishXfer("R2");
    checkIdle("R2");

    // R3 recall sequence
    expectPulse(2, "R3");
    prefix5(); rd(13'h0F0E);
    finishXfer("R3");
    checkIdle("R3");

    // R4 write with matching address aborts, then a read of step 4 cannot continue
    rd(13'h0000); rd(13'h1555); access(13'h0AAA, 1'b1, 1);
    rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
    repeat (2) @(negedge clk);
    checkIdle("R4");
    // R4 write at last step aborts
    prefix5(); access(13'h0F0F, 1'b1, 1);
    repeat (2) @(negedge clk);
    checkIdle("R4");

    // R5 non-zero mismatch aborts
    rd(13'h0000); rd(13'h1555); rd(13'h1234); rd(13'h0AAA);
    rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
    repeat (2) @(negedge clk);
    checkIdle("R5");
    // R5 wrong sixth address aborts
    prefix5(); rd(13'h0F0D); rd(13'h0F0F);
    repeat (2) @(negedge clk);
    checkIdle("R5");
    // R5 stray 0x0000 restarts at step two
    expectPulse(1, "R5");
    rd(13'h0000); rd(13'h1555); rd(13'h0000); rd(13'h1555);
    rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F);
    finishXfer("R5");
    checkIdle("R5");

    // R6 long strobe counts once
    expectPulse(2, "R6");
    rd(13'h0000); access(13'h1555, 1'b0, 4); rd(13'h0AAA);
    access(13'h1FFF, 1'b0, 3); rd(13'h10F0); rd(13'h0F0E);
    // R7 accesses during busy are ignored
    prefix5(); rd(13'h0F0F);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R7", "pulse during busy", expQ.size(), 0);
    finishXfer("R7");
    // R7 state restarted: tail alone does nothing, full sequence works
    rd(13'h0F0F);
    repeat (2) @(negedge clk);
    checkIdle("R7");
    expectPulse(1, "R7");
    prefix5(); rd(13'h0F0F);
    finishXfer("R7");
    checkIdle("R9");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule